// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block is a clocked front end for an external asynchronous static RAM with a 16-bit data path. A host posts one request at a time: an 18-bit word address, a read/write flag, write data and a per-byte lane mask. The controller turns each request into a timed sequence on the RAM's active-low chip select, write strobe, output enable and per-byte lane enables. Each phase is stretched by a parameter counted in clock cycles, so the RAM's minimum access, pulse and setup times are met at the chosen clock rate.

A write holds output enable high throughout. It runs a setup phase with the write strobe high, then a pulse phase with the strobe low, then a recovery phase in which the RAM is deselected. The controller drives the data bus only during setup and pulse. A read holds chip select and output enable low for an access phase and captures the lane-masked data on its last cycle. It then runs the same deselected recovery. A write that directly follows a read gets one extra idle cycle, so the RAM's output drivers are off before the controller's drivers come on. The host sees `reqReady` high only while the controller is idle. A single-cycle `rdValid` pulse marks returned read data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, with no request, `memCeN`, `memWeN`, `memOeN` and every `memBeN` bit are 1, `memDqOe` is 0, `reqReady` is 1 and `rdValid` is 0.
- R2: A write accepted at a clock edge (with `reqValid`=1 and `reqReady`=1) first spends SETUP_CYC cycles with `memCeN`=0, `memWeN`=1 and `memOeN`=1. It then spends PULSE_CYC cycles with `memWeN`=0, `memCeN`=0 and `memOeN`=1. It then spends RECOV_CYC cycles with all strobes high. `memAddr` equals the request address while the RAM is selected.
- R3: `memDqOe` is 1 only during the setup and pulse phases of a write, with `memDqOut` equal to the write data. It is never 1 while `memOeN`=0.
- R4: A read spends READ_CYC cycles with `memCeN`=0, `memOeN`=0, `memWeN`=1 and `memDqOe`=0, then RECOV_CYC cycles with all strobes high.
- R5: Mask bit 0 selects the lower lane (data bits 7:0, driven as `memBeN[0]`=0). Mask bit 1 selects the upper lane (bits 15:8, `memBeN[1]`=0). A lane is enabled only while the RAM is selected. A write leaves the bytes of unselected lanes unchanged.
- R6: Read data is captured on the last access cycle. `rdValid` is 1 for exactly one cycle, the first recovery cycle, and `rdData` bits of unselected lanes read as 0.
- R7: `reqReady` is 0 from the cycle after acceptance until the last recovery cycle ends. A `reqValid` raised while `reqReady`=0 has no effect.
- R8: A write accepted when the previous access was a read first spends one cycle with all strobes high and `memDqOe`=0, before its setup phase begins.
- R9: `memWeN` and `memOeN` are never 0 together, and `memWeN`=0 only while `memCeN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is 1 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| reqReady | output | 1 | Controller idle and able to take a request |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| rdData | output | 16 | Captured read data, unselected lanes zero |
| memAddr | output | 18 | RAM address |
| memCeN | output | 1 | RAM chip select, active low |
| memWeN | output | 1 | RAM write strobe, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memBeN | output | 2 | RAM lane enables, active low, bit 0 = low byte |
| memDqOut | output | 16 | Data toward the RAM |
| memDqOe | output | 1 | Drive enable for memDqOut on the shared pins |
| memDqIn | input | 16 | Data from the RAM pins |

## Verification
The main function is tried with full-word, low-only and high-only lane masks, for both writes and reads, on the same address.

- Overlapping byte writes show whether an unselected lane is really left alone.
- Narrow reads of a known word show whether the masked lane is zeroed instead of passing through the bus value.

The access order is varied as well:

- write after write, which must carry no extra cycle;
- write after read, which must insert the turnaround cycle;
- a request raised while busy, which must leave memory untouched.

A pin-level monitor watches every cycle for the data drivers and the RAM outputs being on together.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_PULSE,
    ST_RACC,
    ST_RECOV
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic ceOn;     // select the RAM
    logic weOn;     // write pulse
    logic oeOn;     // RAM output drivers on
    logic laneOn;   // apply lane mask to enables
    logic dqDrive;  // controller drives data pins
    logic capture;  // sample read data
  } strobe_t;

  function automatic int maxOf4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int RECOV_CYC = 1,
  parameter int READ_CYC  = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int MAXC  = maxOf4(SETUP_CYC, PULSE_CYC, RECOV_CYC, READ_CYC);
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(READ_CYC - 1);

  phase_t         state;
  logic [CNT_W-1:0] cnt;
  logic           lastRead;
  logic           accept;
  logic           cntDone;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign cntDone  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reqWrite) begin
              state    <= lastRead ? ST_TURN : ST_SETUP;
              cnt      <= SETUP_LD;
              lastRead <= 1'b0;
            end else begin
              state    <= ST_RACC;
              cnt      <= READ_LD;
              lastRead <= 1'b1;
            end
          end
        end
        ST_TURN: begin
          state <= ST_SETUP;
          cnt   <= SETUP_LD;
        end
        ST_SETUP: begin
          if (cntDone) begin
            state <= ST_PULSE;
            cnt   <= PULSE_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cntDone) begin
            state <= ST_RECOV;
            cnt   <= RECOV_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RACC: begin
          if (cntDone) begin
            state <= ST_RECOV;
            cnt   <= RECOV_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOV: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = accept;
    stb.ceOn    = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_RACC);
    stb.weOn    = (state == ST_PULSE);
    stb.oeOn    = (state == ST_RACC);
    stb.laneOn  = stb.ceOn;
    stb.dqDrive = (state == ST_SETUP) || (state == ST_PULSE);
    stb.capture = (state == ST_RACC) && cntDone;
  end

  // last recovery cycle hands control back to the host
  assert_ready_after_recov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV && cntDone) |=> reqReady);

  // a turnaround cycle only ever follows a read
  assert_turn_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN) |-> ($past(state) == ST_IDLE && $past(lastRead)));

  // phase counter stays within its longest load value
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) < MAXC));

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (stb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdValid <= 1'b0;
    else        rdValid <= stb.capture;
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~stb.ceOn;
  assign memWeN   = ~stb.weOn;
  assign memOeN   = ~stb.oeOn;
  assign memDqOut = wdataQ;
  assign memDqOe  = stb.dqDrive;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memBeN[g] = ~(stb.laneOn & maskQ[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdData[g*8 +: 8] <= '0;
      end else if (stb.capture) begin
        rdData[g*8 +: 8] <= maskQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
      end
    end
  end

  assert_wr_oe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (memOeN && !memCeN));

  assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
    memDqOe |-> memOeN);

  assert_drive_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |=> !memDqOe);

  assert_rdvalid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid);

  assert_lanes_need_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (memBeN != '1) |-> !memCeN);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int RECOV_CYC = 1,
  parameter int READ_CYC  = 3,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t stb;

  sram_lane_fsm #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC),
    .READ_CYC (READ_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  sram_lane_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memBeN  (memBeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int SETUP_CYC = 1;
  localparam int PULSE_CYC = 2;
  localparam int RECOV_CYC = 1;
  localparam int READ_CYC  = 3;
  localparam int WR_BUSY   = SETUP_CYC + PULSE_CYC + RECOV_CYC;
  localparam int RD_BUSY   = READ_CYC + RECOV_CYC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rdValid;
  logic [15:0] rdData;
  logic [17:0] memAddr;
  logic        memCeN, memWeN, memOeN, memDqOe;
  logic [1:0]  memBeN;
  logic [15:0] memDqOut, memDqIn;

  always #2 clk = ~clk;  // 250 MHz

  sram_lane_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC), .READ_CYC(READ_CYC)
  ) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // small RAM model, indexed by the low address bits
  logic [15:0] ram [64];
  logic [5:0]  idx;
  assign idx = memAddr[5:0];
  assign memDqIn = (!memCeN && !memOeN) ?
    {(!memBeN[1] ? ram[idx][15:8] : 8'h5A), (!memBeN[0] ? ram[idx][7:0] : 8'hC3)} : 16'h0000;

  int nTests = 0;
  int nFail  = 0;
  int conflicts = 0;
  bit prevRead = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!memCeN && !memWeN) begin
        if (!memBeN[0]) ram[idx][7:0]  <= memDqOut[7:0];
        if (!memBeN[1]) ram[idx][15:8] <= memDqOut[15:8];
      end
      if ((memDqOe && !memOeN) || (!memWeN && !memOeN) || (!memWeN && memCeN))
        conflicts++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin snapshot {ce, we, oe, be1, be0, dqOe}
  function automatic logic [5:0] pins();
    return {memCeN, memWeN, memOeN, memBeN[1], memBeN[0], memDqOe};
  endfunction

  // at a negedge with reqReady high: present a request, release it next negedge
  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    prevRead = !w;
  endtask

  // complete access; returns busy cycles, read data and the cycle rdValid was seen
  task automatic access(input bit w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, output int busy, output logic [15:0] rd,
                        output int rdAt);
    busy = 0; rdAt = 0; rd = '0;
    while (!reqReady) @(negedge clk);
    issue(w, a, d, m);
    while (!reqReady) begin
      busy++;
      if (!memCeN && memAddr !== a) check("R2 address held", memAddr, a);
      if (rdValid) begin rd = rdData; rdAt = busy; end
      @(negedge clk);
    end
  endtask

  localparam int NV = 10;
  localparam bit          VW [NV] = '{1, 0, 1, 0, 1, 0, 0, 0, 1, 0};
  localparam logic [17:0] VA [NV] = '{18'h10005, 18'h10005, 18'h10005, 18'h10005, 18'h00009,
                                      18'h00009, 18'h00009, 18'h10005, 18'h3FFFF, 18'h3FFFF};
  localparam logic [15:0] VD [NV] = '{16'h1234, 16'h0, 16'hABFF, 16'h0, 16'hEECD,
                                      16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0};
  localparam logic [1:0]  VM [NV] = '{2'b11, 2'b11, 2'b10, 2'b11, 2'b01,
                                      2'b01, 2'b10, 2'b10, 2'b11, 2'b01};
  localparam logic [15:0] VE [NV] = '{16'h0, 16'h1234, 16'h0, 16'hAB34, 16'h0,
                                      16'h00CD, 16'h0000, 16'hAB00, 16'h0, 16'h00FF};

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int busy, rdAt;
    logic [15:0] rd;
    bit expTurn;
    for (int i = 0; i < 64; i++) ram[i] = 16'h0000;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pins in reset", pins(), 6'b111110);
    check("R1 ready/valid in reset", {reqReady, rdValid}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pins after reset", pins(), 6'b111110);
    check("R1 ready/valid after reset", {reqReady, rdValid}, 2'b10);

    // R2 R3 R5: upper-lane write, cycle by cycle
    issue(1'b1, 18'h00003, 16'h77EE, 2'b10);
    check("R2 setup pins", pins(), 6'b011011);
    check("R3 setup data", memDqOut, 16'h77EE);
    check("R7 busy in setup", reqReady, 1'b0);
    @(negedge clk);
    check("R2 pulse pins c1", pins(), 6'b001011);
    @(negedge clk);
    check("R2 pulse pins c2", pins(), 6'b001011);
    @(negedge clk);
    check("R2 recovery pins", pins(), 6'b111110);
    check("R7 busy in recovery", reqReady, 1'b0);
    @(negedge clk);
    check("R7 ready after write", reqReady, 1'b1);
    check("R5 upper byte written only", ram[3], 16'h7700);

    // R4 R6: full-word read, cycle by cycle
    issue(1'b0, 18'h00003, 16'h0, 2'b11);
    check("R4 access pins c1", pins(), 6'b010000);
    @(negedge clk);
    check("R4 access pins c2", pins(), 6'b010000);
    @(negedge clk);
    check("R4 access pins c3", pins(), 6'b010000);
    check("R6 no early valid", rdValid, 1'b0);
    @(negedge clk);
    check("R4 recovery pins", pins(), 6'b111110);
    check("R6 valid in first recovery", rdValid, 1'b1);
    check("R6 read data", rdData, 16'h7700);
    @(negedge clk);
    check("R6 valid single cycle", rdValid, 1'b0);
    check("R7 ready after read", reqReady, 1'b1);

    // R8: write right after the read gets a turnaround cycle
    issue(1'b1, 18'h00004, 16'h4444, 2'b11);
    check("R8 turnaround pins", pins(), 6'b111110);
    check("R8 busy in turnaround", reqReady, 1'b0);
    @(negedge clk);
    check("R8 setup after turnaround", pins(), 6'b011001);
    repeat (4) @(negedge clk);
    check("R8 write completed", ram[4], 16'h4444);

    // R7: a request while busy is ignored
    while (!reqReady) @(negedge clk);
    issue(1'b1, 18'h00014, 16'h1111, 2'b11);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00014; reqWdata = 16'h2222; reqMask = 2'b11;
    @(negedge clk);
    reqValid = 1'b0;
    access(1'b0, 18'h00014, 16'h0, 2'b11, busy, rd, rdAt);
    check("R7 busy request ignored", rd, 16'h1111);

    // vector table: masks, orderings and cycle counts
    for (int v = 0; v < NV; v++) begin
      expTurn = prevRead;
      access(VW[v], VA[v], VD[v], VM[v], busy, rd, rdAt);
      if (VW[v]) begin
        check($sformatf("R2 R8 write busy cycles v%0d", v), busy, WR_BUSY + (expTurn ? 1 : 0));
      end else begin
        check($sformatf("R4 read busy cycles v%0d", v), busy, RD_BUSY);
        check($sformatf("R6 valid timing v%0d", v), rdAt, READ_CYC + 1);
        check($sformatf("R5 R6 lane data v%0d", v), rd, VE[v]);
      end
    end

    check("R3 R9 pin conflicts", conflicts, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule